// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block is the master for a small three-wire serial EEPROM that holds 64 words of 16 bits. A caller presents one command at a time: read a word, write a word, erase a word, enable writes, or disable writes. The block turns the command into a single framed serial transfer. It drives chip select, the serial clock and the data line toward the memory, and it samples the data line that comes back. When the command is complete it pulses `done`. A read also returns the word it fetched.

An erase needs a second step. The memory keeps working on its own after the erase frame has ended. The block therefore selects the device again and polls its output until the device reports ready. If the device never reports ready, the block stops after a bounded number of polls and flags a timeout. The serial clock level time is a parameter counted in system clock cycles. The polling bound is also a parameter.

Top module: `mw_eeprom_master`

## Requirements
- R1: While `ready` is high, `mw_cs`, `mw_sk` and `mw_di` are all low. Each frame begins when `mw_cs` rises and ends when it falls.
- R2: Every frame is shifted most significant bit first. The order is a start bit of 1, then a 2-bit opcode, then a 6-bit address. The memory takes each bit from `mw_di` on the rising edge of `mw_sk`.
- R3: `cmd` encoding: 0 is read (opcode 10), 1 is write (opcode 01), 2 is erase (opcode 11), 3 is write-enable (opcode 00), and 4 to 7 are write-disable (opcode 00).
- R4: Read and write frames carry 16 data bits after the address, which makes 25 `mw_sk` pulses. A write sends `wdata` most significant bit first. A read sends zeros. Erase, write-enable and write-disable frames end after 9 pulses.
- R5: Write-enable puts 6'b110000 in the address field and write-disable puts 6'b000000 there, whatever is on `addr`. A memory that has been disabled ignores writes, and one that has been enabled accepts them.
- R6: `mw_sk` is high only while `mw_cs` is high. `mw_di` does not change while `mw_sk` stays high.
- R7: A read samples `mw_do` after each of the last 16 falling edges of `mw_sk`, most significant bit first. The resulting word appears on `rdata` in the same cycle as `done`.
- R8: Every high level and every low level of `mw_sk` lasts at least HALF clock cycles.
- R9: After an erase frame, `mw_cs` stays low for HALF cycles and then rises again with no clock pulses. `mw_do` is polled every HALF cycles. The first poll that reads 1 drops `mw_cs` and completes the command with `timeout_err` low.
- R10: If POLL_MAX polls all read 0, `mw_cs` drops and `done` is given with `timeout_err` high. The flag keeps that value until the next `done`.
- R11: A `req` is taken only while `ready` is high, and `ready` falls in the next cycle. A `req` raised while the block is busy has no effect. `done` is a one-cycle pulse, given in the cycle in which `ready` returns.
- R12: A synchronous active-high `rst` leaves the block idle, with `ready` high and every other output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Command request |
| cmd | input | 3 | Command class |
| addr | input | 6 | Word address |
| wdata | input | 16 | Word to write |
| ready | output | 1 | Idle, able to take a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Word fetched by the last read |
| timeout_err | output | 1 | The last erase never reported ready |
| mw_cs | output | 1 | Chip select to the memory |
| mw_sk | output | 1 | Serial clock to the memory |
| mw_di | output | 1 | Serial data to the memory |
| mw_do | input | 1 | Serial data from the memory |

## Verification
The case that is hardest to reach from the ports is a timeout on the erase poll. A healthy memory always finishes its erase, so the timeout path never runs on its own. The bench memory model has a stuck flag that keeps its ready output low. The bench sets that flag for one erase, with POLL_MAX reduced so the bound is hit quickly. It then clears the flag and runs a normal read to show that `timeout_err` returns to low. A second case is a request raised while the block is busy: the bench raises it in the middle of a frame, and the scoreboard must then see no extra frame.

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master #(
  parameter int HALF     = 4,
  parameter int POLL_MAX = 65535
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [2:0]  cmd,
  input  logic [5:0]  addr,
  input  logic [15:0] wdata,
  output logic        ready,
  output logic        done,
  output logic [15:0] rdata,
  output logic        timeout_err,
  output logic        mw_cs,
  output logic        mw_sk,
  output logic        mw_di,
  input  logic        mw_do
);
  localparam int TW    = $clog2(HALF + 1);
  localparam int PW    = $clog2(POLL_MAX + 1);
  localparam int FRAME = 25;
  localparam int HDR   = 9;

  typedef enum logic [2:0] {S_IDLE, S_CSUP, S_SETUP, S_HIGH, S_TAIL, S_CSDN, S_POLL, S_PEND} st_t;

  st_t               state;
  logic [TW-1:0]     tmr;
  logic [FRAME-1:0]  shreg;
  logic [4:0]        bitcnt;
  logic [15:0]       rx;
  logic [PW-1:0]     pollcnt;
  logic              is_erase, is_read, fail;

  logic [1:0]  op;
  logic [5:0]  a_eff;
  logic        has_data;
  logic        tick;

  assign tick  = (tmr == '0);
  assign ready = (state == S_IDLE);

  always_comb begin
    op       = 2'b00;
    a_eff    = 6'b000000;
    has_data = 1'b0;
    case (cmd)
      3'd0: begin op = 2'b10; a_eff = addr; has_data = 1'b1; end
      3'd1: begin op = 2'b01; a_eff = addr; has_data = 1'b1; end
      3'd2: begin op = 2'b11; a_eff = addr; end
      3'd3: a_eff = 6'b110000;
      default: a_eff = 6'b000000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      tmr         <= TW'(HALF - 1);
      shreg       <= '0;
      bitcnt      <= '0;
      rx          <= '0;
      pollcnt     <= '0;
      is_erase    <= 1'b0;
      is_read     <= 1'b0;
      fail        <= 1'b0;
      done        <= 1'b0;
      rdata       <= '0;
      timeout_err <= 1'b0;
      mw_cs       <= 1'b0;
      mw_sk       <= 1'b0;
      mw_di       <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE || tick) tmr <= TW'(HALF - 1);
      else                         tmr <= tmr - 1'b1;
      case (state)
        S_IDLE: if (req) begin
          shreg    <= {1'b1, op, a_eff, (cmd == 3'd1) ? wdata : 16'h0000};
          bitcnt   <= has_data ? 5'(FRAME) : 5'(HDR);
          is_erase <= (cmd == 3'd2);
          is_read  <= (cmd == 3'd0);
          fail     <= 1'b0;
          mw_cs    <= 1'b1;
          state    <= S_CSUP;
        end
        S_CSUP: if (tick) begin
          mw_di <= shreg[FRAME-1];
          state <= S_SETUP;
        end
        S_SETUP: if (tick) begin
          mw_sk <= 1'b1;
          state <= S_HIGH;
        end
        S_HIGH: if (tick) begin
          mw_sk <= 1'b0;
          state <= S_TAIL;
        end
        S_TAIL: if (tick) begin
          rx     <= {rx[14:0], mw_do};
          shreg  <= shreg << 1;
          bitcnt <= bitcnt - 1'b1;
          if (bitcnt == 5'd1) begin
            mw_di <= 1'b0;
            mw_cs <= 1'b0;
            state <= S_CSDN;
          end else begin
            mw_di <= shreg[FRAME-2];
            state <= S_SETUP;
          end
        end
        S_CSDN: if (tick) begin
          if (is_erase) begin
            mw_cs   <= 1'b1;
            pollcnt <= '0;
            state   <= S_POLL;
          end else begin
            done        <= 1'b1;
            timeout_err <= fail;
            if (is_read) rdata <= rx;
            state       <= S_IDLE;
          end
        end
        S_POLL: if (tick) begin
          if (mw_do) begin
            mw_cs <= 1'b0;
            state <= S_PEND;
          end else if (pollcnt == PW'(POLL_MAX - 1)) begin
            fail  <= 1'b1;
            mw_cs <= 1'b0;
            state <= S_PEND;
          end else begin
            pollcnt <= pollcnt + 1'b1;
          end
        end
        S_PEND: if (tick) begin
          done        <= 1'b1;
          timeout_err <= fail;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mw_eeprom_master_chk.sv
module mw_eeprom_master_chk #(
  parameter int HALF = 4
) (
  input logic clk,
  input logic rst,
  input logic req,
  input logic ready,
  input logic done,
  input logic timeout_err,
  input logic mw_cs,
  input logic mw_sk,
  input logic mw_di
);
  localparam int CW = $clog2(HALF + 1);
  logic [CW-1:0] lvl_cnt;
  logic          sk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_cnt <= CW'(HALF);
      sk_q    <= 1'b0;
    end else begin
      sk_q <= mw_sk;
      if (mw_sk != sk_q)           lvl_cnt <= CW'(1);
      else if (lvl_cnt < CW'(HALF)) lvl_cnt <= lvl_cnt + 1'b1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!mw_cs && !mw_sk && !mw_di));
  assert_sk_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    mw_sk |-> mw_cs);
  assert_di_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (mw_sk && $past(mw_sk)) |-> $stable(mw_di));
  assert_sk_level_R8: assert property (@(posedge clk) disable iff (rst)
    (mw_sk != sk_q) |-> (lvl_cnt >= CW'(HALF)));
  assert_err_with_done_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(timeout_err) |-> done);
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);
  assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
    (req && ready) |=> !ready);
endmodule

bind mw_eeprom_master mw_eeprom_master_chk #(.HALF(HALF)) chk_i (
  .clk(clk), .rst(rst), .req(req), .ready(ready), .done(done),
  .timeout_err(timeout_err), .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di)
);

// File: tb/mw_eeprom_master_tb_top.sv
module mw_eeprom_master_tb_top;
  localparam int HALF = 2;
  localparam int PMAX = 40;
  localparam int BUSY = 30;

  logic clk = 0, rst = 1, req = 0;
  logic [2:0] cmd = 0;
  logic [5:0] addr = 0;
  logic [15:0] wdata = 0;
  logic ready, done, timeout_err, mw_cs, mw_sk, mw_di, mw_do;
  logic [15:0] rdata;

  always #10 clk = ~clk;

  mw_eeprom_master #(.HALF(HALF), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst(rst), .req(req), .cmd(cmd), .addr(addr), .wdata(wdata),
    .ready(ready), .done(done), .rdata(rdata), .timeout_err(timeout_err),
    .mw_cs(mw_cs), .mw_sk(mw_sk), .mw_di(mw_di), .mw_do(mw_do));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] initv(input int i);
    return 16'(i * 37 + 5);
  endfunction

  // scoreboard queues
  int          exp_n[$];
  logic [24:0] exp_v[$];

  // memory model
  logic [15:0] mem [64];
  logic        en = 0, stuck = 0, prev_sk = 0, prev_cs = 0, dout = 0;
  logic [24:0] cap = 0;
  logic [1:0]  rd_op = 0;
  logic [5:0]  rd_a = 0;
  int nrise = 0, busy = 0, sk_hi = 0, polls_seen = 0;

  assign mw_do = (mw_cs && nrise == 0) ? (busy == 0 && !stuck) : dout;

  initial for (int i = 0; i < 64; i++) mem[i] = initv(i);

  always @(negedge clk) begin
    if (busy > 0) busy--;
    if (mw_sk) sk_hi++;
    if (!mw_sk && prev_sk) begin
      chk(sk_hi >= HALF, "R8 sk high time", sk_hi, HALF);
      sk_hi = 0;
    end
    if (mw_sk && !prev_sk) begin
      cap = {cap[23:0], mw_di};
      nrise++;
      if (nrise == 9) begin
        rd_op = cap[7:6];
        rd_a  = cap[5:0];
        dout  = 1'b0;
      end else if (nrise >= 10 && nrise <= 25 && rd_op == 2'b10) begin
        dout = mem[rd_a][25 - nrise];
      end
    end
    if (!mw_cs && prev_cs) begin
      if (nrise == 0) polls_seen++;
      else begin
        if (exp_n.size() == 0) chk(0, "R11 unexpected frame", cap, 0);
        else begin
          int en_n;
          logic [24:0] ev;
          en_n = exp_n.pop_front();
          ev   = exp_v.pop_front();
          chk(nrise == en_n, "R4 clock pulses in frame", nrise, en_n);
          chk(cap == ev, "R2 frame bits", cap, ev);
        end
        if (nrise == 25 && cap[23:22] == 2'b01 && en) mem[cap[21:16]] = cap[15:0];
        if (nrise == 9 && cap[7:6] == 2'b11 && en) begin
          mem[cap[5:0]] = 16'hFFFF;
          busy = BUSY;
        end
        if (nrise == 9 && cap[7:6] == 2'b00) begin
          if (cap[5:4] == 2'b11) en = 1;
          if (cap[5:4] == 2'b00) en = 0;
        end
      end
      nrise = 0;
      cap   = 0;
      dout  = 0;
      rd_op = 0;
    end
    prev_sk = mw_sk;
    prev_cs = mw_cs;
  end

  task automatic run(input logic [2:0] c, input logic [5:0] a, input logic [15:0] wd,
                     input bit ck_rd, input logic [15:0] exp_rd, input bit exp_err,
                     input bit poke, input string rq);
    logic [1:0] op;
    logic [5:0] ae;
    bit dat;
    case (c)
      3'd0: begin op = 2'b10; ae = a; dat = 1; end
      3'd1: begin op = 2'b01; ae = a; dat = 1; end
      3'd2: begin op = 2'b11; ae = a; dat = 0; end
      3'd3: begin op = 2'b00; ae = 6'b110000; dat = 0; end
      default: begin op = 2'b00; ae = 6'b000000; dat = 0; end
    endcase
    if (dat) begin
      exp_n.push_back(25);
      exp_v.push_back({1'b1, op, ae, (c == 3'd1) ? wd : 16'h0000});
    end else begin
      exp_n.push_back(9);
      exp_v.push_back({16'h0000, 1'b1, op, ae});
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    req = 1; cmd = c; addr = a; wdata = wd;
    @(negedge clk);
    req = 0;
    chk(!ready, "R11 ready drops after accept", ready, 0);
    if (poke) begin
      repeat (20) @(negedge clk);
      req = 1; cmd = 3'd1; addr = 6'd1; wdata = 16'hDEAD;
      @(negedge clk);
      req = 0;
    end
    while (!done) @(negedge clk);
    chk(ready, "R11 done with ready", ready, 1);
    chk(timeout_err == exp_err, {rq, " timeout flag"}, timeout_err, exp_err);
    if (ck_rd) chk(rdata == exp_rd, {rq, " read data"}, rdata, exp_rd);
    @(negedge clk);
    chk(!done, "R11 done one cycle", done, 0);
    chk({mw_cs, mw_sk, mw_di} == 3'b000, "R1 idle lines low", {mw_cs, mw_sk, mw_di}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ready && !done && !timeout_err && rdata == 0 && !mw_cs && !mw_sk && !mw_di,
        "R12 reset state", {ready, done, timeout_err, mw_cs, mw_sk, mw_di}, 6'b100000);
    // R5: write while disabled is ignored
    run(3'd1, 6'd5, 16'h1111, 0, 0, 0, 0, "R5 write disabled");
    run(3'd0, 6'd5, 0, 1, initv(5), 0, 0, "R5 read after ignored write");
    // R5 R3: enable with a junk address
    run(3'd3, 6'h0A, 0, 0, 0, 0, 0, "R5 enable");
    run(3'd1, 6'd0, 16'hA5C3, 0, 0, 0, 0, "R3 write");
    run(3'd1, 6'd63, 16'h8001, 0, 0, 0, 0, "R3 write top");
    run(3'd1, 6'd17, 16'h0000, 0, 0, 0, 0, "R3 write zero");
    run(3'd0, 6'd0, 0, 1, 16'hA5C3, 0, 0, "R7 read A5C3");
    run(3'd0, 6'd63, 0, 1, 16'h8001, 0, 0, "R7 read top");
    run(3'd0, 6'd17, 0, 1, 16'h0000, 0, 0, "R7 read zero");
    run(3'd0, 6'd42, 0, 1, initv(42), 0, 0, "R7 read init");
    // R9 erase with ready poll
    p0 = polls_seen;
    run(3'd2, 6'd17, 0, 0, 0, 0, 0, "R9 erase");
    chk(polls_seen == p0 + 1, "R9 poll window seen", polls_seen, p0 + 1);
    run(3'd0, 6'd17, 0, 1, 16'hFFFF, 0, 0, "R9 read erased");
    // R11 request while busy ignored
    run(3'd0, 6'd63, 0, 1, 16'h8001, 0, 1, "R11 busy request ignored");
    run(3'd0, 6'd1, 0, 1, initv(1), 0, 0, "R11 word 1 untouched");
    // R5 disable then write ignored
    run(3'd4, 6'h3F, 0, 0, 0, 0, 0, "R5 disable");
    run(3'd1, 6'd0, 16'h1234, 0, 0, 0, 0, "R5 write after disable");
    run(3'd0, 6'd0, 0, 1, 16'hA5C3, 0, 0, "R5 read after disable");
    // R10 timeout
    run(3'd3, 6'd0, 0, 0, 0, 0, 0, "R10 enable");
    stuck = 1;
    run(3'd2, 6'd3, 0, 0, 0, 1, 0, "R10 erase timeout");
    stuck = 0;
    run(3'd0, 6'd3, 0, 1, 16'hFFFF, 0, 0, "R10 flag cleared");
    chk(exp_n.size() == 0, "R11 all frames seen", exp_n.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule